// File: doc/BRIEF.md
# SDRAM Mode-Register Programmer via Address Windows

This block sits between a processor's memory-mapped write port and the command pins of an SDRAM controller that serves two memory areas. A processor write that lands in either of two reserved 64 KiB address windows does not carry data. The block reads the mode value from the low offset bits of the address, so it has no data input at all. It checks that offset and turns it into a mode-register-set command on the chip select of the addressed area. The value goes out on the SDRAM address pins, shifted to match how those pins connect for the configured bus width.

The block also holds one "programmed" flag per area. Normal accesses to an area pass the block's gate only after that area has received a mode-register-set command. The state machine has six named states:

- `ST_IDLE` accepts a one-cycle request strobe.
- `ST_REJECT` acknowledges a bad request with an error for one cycle.
- `ST_WAIT_PRE` waits until the controller reports that every bank is precharged.
- `ST_ISSUE` drives the command for one cycle.
- `ST_HOLD` blocks other commands for the mode-register delay.
- `ST_ACK` acknowledges the processor.

The transitions are:

- IDLE to REJECT on a window read, an offset out of range, or an illegal burst code.
- IDLE to WAIT_PRE on a legal window write.
- WAIT_PRE to ISSUE when precharge is complete.
- ISSUE to HOLD.
- HOLD to ACK after the delay.
- REJECT to IDLE and ACK to IDLE.

Top module: `sdram_mrs_writer`

## Requirements
- R1: Window `0xFF90_xxxx` selects area index 0 and window `0xFF94_xxxx` selects area index 1. The command pulls only `sd_cs_n[area]` low, and at most one chip select is ever low.
- R2: With `cfg_bus64`=0 (32-bit bus), `sd_addr` during the command carries address bits [15:2] of the request, truncated to 13 bits.
- R3: With `cfg_bus64`=1 (64-bit bus), `sd_addr` during the command carries address bits [15:3].
- R4: A window write whose offset (bits [15:0]) is above `0x0FFC` is refused: one cycle of `cpu_ack` with `cpu_err`, and no command. Offset `0x0FEC` with a legal burst code is accepted.
- R5: Bits [2:0] of the shifted mode value are the burst code, where 010 means 4 and 011 means 8. On a 32-bit bus both codes are legal. On a 64-bit bus only 010 is legal. Any other code is refused as in R4.
- R6: A read inside either window is refused as in R4 and never produces a command.
- R7: After a legal write, the block waits in `ST_WAIT_PRE` until `all_precharged` is sampled high. The command appears in the cycle after that sample.
- R8: The command holds `sd_ras_n`, `sd_cas_n` and `sd_we_n` low for exactly one cycle. It is followed by `TMRD` deselected cycles with `cmd_busy` high, and then one cycle of `cpu_ack` without `cpu_err`.
- R9: Both area flags clear on reset. `norm_req` to an area whose flag is clear raises `norm_err` and no `norm_gnt`. A command to an area sets its flag, and afterwards an idle `norm_req` to that area gets `norm_gnt` in the same cycle.
- R10: Requests outside both windows are ignored. A strobe that arrives while the block is busy is ignored and does not change the sequence in progress.
- R11: During and after reset, all chip selects and command pins sit high, `sd_addr` is 0, and `cpu_ack`, `cpu_err` and `cmd_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus64 | input | 1 | 1 = 64-bit SDRAM bus, 0 = 32-bit |
| cpu_req | input | 1 | One-cycle request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Request address |
| cpu_ack | output | 1 | Request completed |
| cpu_err | output | 1 | Request refused (valid with `cpu_ack`) |
| all_precharged | input | 1 | All banks are precharged |
| sd_cs_n | output | 2 | Per-area chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | SDRAM address pins (mode value) |
| cmd_busy | output | 1 | Block owns the command pins |
| norm_req | input | 1 | Normal access request |
| norm_area | input | 1 | Area of the normal access |
| norm_gnt | output | 1 | Normal access allowed |
| norm_err | output | 1 | Normal access refused, area not programmed |

## Verification
The timing of each result, counted from the clock edge that samples a strobe, is as follows:

- A refused request shows `cpu_ack` with `cpu_err` in the very next cycle.
- A legal write shows `ST_WAIT_PRE` in the next cycle.
- The command appears one cycle after the edge that sees `all_precharged` high.
- The acknowledge follows `TMRD`+1 cycles after the command.
- The normal-access gate answers combinationally in the same cycle.

The bench builds a queue of expected per-cycle pin records from these rules when it applies a strobe. It pops one record at every falling edge, so each output is compared halfway between the edge that changes it and the next edge. Normal-access probes are compared 1 ns after the inputs change.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_WAIT_PRE,
        ST_ISSUE,
        ST_HOLD,
        ST_ACK
    } mrs_state_t;

    localparam logic [2:0] BURST4_CODE = 3'b010;
    localparam logic [2:0] BURST8_CODE = 3'b011;

endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
    import sdram_mrs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int N_AREA    = 2,
    parameter int AREA_W    = 1,
    parameter int SD_ADDR_W = 13,
    parameter logic [N_AREA*(ADDR_W-OFF_W)-1:0] WIN_BASES = {16'hFF94, 16'hFF90},
    parameter logic [OFF_W-1:0] MAX_OFF = 16'h0FFC
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 bus64,
    output logic                 win_hit,
    output logic [AREA_W-1:0]    area,
    output logic                 range_ok,
    output logic                 burst_ok,
    output logic [SD_ADDR_W-1:0] mode_val
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic [N_AREA-1:0] hit_vec;
    logic [2:0]        burst_code;

    assign page = addr[ADDR_W-1:OFF_W];
    assign off  = addr[OFF_W-1:0];

    for (genvar g = 0; g < N_AREA; g++) begin : g_win
        assign hit_vec[g] = (page == WIN_BASES[g*PAGE_W +: PAGE_W]);
    end

    always_comb begin
        area = '0;
        for (int i = 0; i < N_AREA; i++) begin
            if (hit_vec[i]) area = AREA_W'(i);
        end
    end

    assign win_hit  = |hit_vec;
    assign range_ok = (off <= MAX_OFF);

    // SDRAM A0 is wired to CPU A2 (32-bit bus) or A3 (64-bit bus)
    assign mode_val   = bus64 ? SD_ADDR_W'(off >> 3) : SD_ADDR_W'(off >> 2);
    assign burst_code = mode_val[2:0];

    always_comb begin
        if (bus64) burst_ok = (burst_code == BURST4_CODE);
        else       burst_ok = (burst_code == BURST4_CODE) || (burst_code == BURST8_CODE);
    end

endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
    import sdram_mrs_pkg::*;
#(
    parameter int N_AREA    = 2,
    parameter int AREA_W    = 1,
    parameter int SD_ADDR_W = 13,
    parameter int TMRD      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 is_write,
    input  logic                 win_hit,
    input  logic                 range_ok,
    input  logic                 burst_ok,
    input  logic [AREA_W-1:0]    area,
    input  logic [SD_ADDR_W-1:0] mode_val,
    input  logic                 all_precharged,
    output logic [N_AREA-1:0]    cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [SD_ADDR_W-1:0] sd_addr,
    output logic                 ack,
    output logic                 err,
    output logic                 busy,
    output logic                 set_prog,
    output logic [AREA_W-1:0]    set_area
);
    localparam int CNT_W = (TMRD > 1) ? $clog2(TMRD) : 1;

    mrs_state_t            state_q, state_d;
    logic [AREA_W-1:0]     area_q;
    logic [SD_ADDR_W-1:0]  val_q;
    logic [CNT_W-1:0]      cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && win_hit) begin
                    if (!is_write || !range_ok || !burst_ok) state_d = ST_REJECT;
                    else                                     state_d = ST_WAIT_PRE;
                end
            end
            ST_REJECT:   state_d = ST_IDLE;
            ST_WAIT_PRE: if (all_precharged) state_d = ST_ISSUE;
            ST_ISSUE:    state_d = ST_HOLD;
            ST_HOLD:     if (cnt_q == CNT_W'(TMRD - 1)) state_d = ST_ACK;
            ST_ACK:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_q <= '0;
            val_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_WAIT_PRE) begin
                area_q <= area;
                val_q  <= mode_val;
            end
            if (state_q == ST_ISSUE)     cnt_q <= '0;
            else if (state_q == ST_HOLD) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cs_n     = '1;
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        sd_addr  = '0;
        ack      = 1'b0;
        err      = 1'b0;
        busy     = (state_q != ST_IDLE);
        set_prog = 1'b0;
        set_area = area_q;
        unique case (state_q)
            ST_REJECT: begin
                ack = 1'b1;
                err = 1'b1;
            end
            ST_ISSUE: begin
                for (int i = 0; i < N_AREA; i++) begin
                    cs_n[i] = (area_q != AREA_W'(i));
                end
                ras_n    = 1'b0;
                cas_n    = 1'b0;
                we_n     = 1'b0;
                sd_addr  = val_q;
                set_prog = 1'b1;
            end
            ST_ACK:  ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mrs_area_flags.sv
module mrs_area_flags #(
    parameter int N_AREA = 2,
    parameter int AREA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_prog,
    input  logic [AREA_W-1:0] set_area,
    input  logic              busy,
    input  logic              norm_req,
    input  logic [AREA_W-1:0] norm_area,
    output logic              norm_gnt,
    output logic              norm_err
);
    logic [N_AREA-1:0] prog_q;

    for (genvar g = 0; g < N_AREA; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                                           prog_q[g] <= 1'b0;
            else if (set_prog && set_area == AREA_W'(g))          prog_q[g] <= 1'b1;
        end
    end

    assign norm_err = norm_req & ~prog_q[norm_area];
    assign norm_gnt = norm_req &  prog_q[norm_area] & ~busy;

endmodule

// File: rtl/sdram_mrs_writer.sv
module sdram_mrs_writer #(
    parameter int ADDR_W    = 32,
    parameter int N_AREA    = 2,
    parameter int AREA_W    = (N_AREA > 1) ? $clog2(N_AREA) : 1,
    parameter int SD_ADDR_W = 13,
    parameter int TMRD      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_bus64,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    output logic                 cpu_ack,
    output logic                 cpu_err,
    input  logic                 all_precharged,
    output logic [N_AREA-1:0]    sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [SD_ADDR_W-1:0] sd_addr,
    output logic                 cmd_busy,
    input  logic                 norm_req,
    input  logic [AREA_W-1:0]    norm_area,
    output logic                 norm_gnt,
    output logic                 norm_err
);
    logic                 win_hit;
    logic [AREA_W-1:0]    dec_area;
    logic                 range_ok;
    logic                 burst_ok;
    logic [SD_ADDR_W-1:0] mode_val;
    logic                 set_prog;
    logic [AREA_W-1:0]    set_area;

    mrs_decode #(
        .ADDR_W(ADDR_W), .OFF_W(16), .N_AREA(N_AREA), .AREA_W(AREA_W),
        .SD_ADDR_W(SD_ADDR_W)
    ) u_decode (
        .addr(cpu_addr), .bus64(cfg_bus64), .win_hit(win_hit), .area(dec_area),
        .range_ok(range_ok), .burst_ok(burst_ok), .mode_val(mode_val)
    );

    mrs_fsm #(
        .N_AREA(N_AREA), .AREA_W(AREA_W), .SD_ADDR_W(SD_ADDR_W), .TMRD(TMRD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .is_write(cpu_we),
        .win_hit(win_hit), .range_ok(range_ok), .burst_ok(burst_ok),
        .area(dec_area), .mode_val(mode_val), .all_precharged(all_precharged),
        .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
        .sd_addr(sd_addr), .ack(cpu_ack), .err(cpu_err), .busy(cmd_busy),
        .set_prog(set_prog), .set_area(set_area)
    );

    mrs_area_flags #(.N_AREA(N_AREA), .AREA_W(AREA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_prog(set_prog), .set_area(set_area),
        .busy(cmd_busy), .norm_req(norm_req), .norm_area(norm_area),
        .norm_gnt(norm_gnt), .norm_err(norm_err)
    );

endmodule

// File: rtl/sdram_mrs_writer_chk.sv
module sdram_mrs_writer_chk #(
    parameter int N_AREA = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              all_precharged,
    input logic              cpu_ack,
    input logic              cpu_err,
    input logic [N_AREA-1:0] sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              cmd_busy,
    input logic              norm_gnt,
    input logic              norm_err
);
    logic mrs_cmd;
    assign mrs_cmd = (~&sd_cs_n) & ~sd_ras_n & ~sd_cas_n & ~sd_we_n;

    // R1
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sd_cs_n));

    // R7
    mrs_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd |-> $past(all_precharged));

    // R8
    mrs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd |=> (&sd_cs_n));

    // R8
    mrs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd |-> cmd_busy);

    // R4
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ack);

    // R9
    norm_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(norm_gnt && norm_err));

    // R9
    norm_gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        norm_gnt |-> !cmd_busy);

endmodule

bind sdram_mrs_writer sdram_mrs_writer_chk #(.N_AREA(N_AREA)) u_chk (.*);

// File: tb/sdram_mrs_writer_tb_top.sv
module sdram_mrs_writer_tb_top;
    localparam int TMRD_TB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus64 = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ack, cpu_err;
    logic        all_precharged = 1'b0;
    logic [1:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic        cmd_busy;
    logic        norm_req = 1'b0;
    logic [0:0]  norm_area = '0;
    logic        norm_gnt, norm_err;

    typedef logic [20:0] rec_t;
    rec_t exp_q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    sdram_mrs_writer #(.TMRD(TMRD_TB)) dut_i (.*);

    function automatic rec_t mk(logic [1:0] cs, logic cmd_low, logic [12:0] a,
                                logic ack, logic err, logic busy);
        return {cs, {3{~cmd_low}}, a, ack, err, busy};
    endfunction

    localparam rec_t IDLE_R   = 21'({2'b11, 3'b111, 13'h0, 1'b0, 1'b0, 1'b0});
    localparam rec_t WAIT_R   = 21'({2'b11, 3'b111, 13'h0, 1'b0, 1'b0, 1'b1});
    localparam rec_t ACK_R    = 21'({2'b11, 3'b111, 13'h0, 1'b1, 1'b0, 1'b1});
    localparam rec_t REJECT_R = 21'({2'b11, 3'b111, 13'h0, 1'b1, 1'b1, 1'b1});

    task automatic check_cycle(input string tag);
        rec_t act, exp;
        @(negedge clk);
        act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, cpu_ack, cpu_err, cmd_busy};
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_R;
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drives a one-cycle strobe; d extra precharge wait cycles
    task automatic mode_write(input logic [31:0] addr, input logic bus64, input int d,
                              input bit ok, input bit intrude, input string tag);
        logic [1:0]  cs;
        logic [12:0] val;
        cs  = (addr[31:16] == 16'hFF94) ? 2'b01 : 2'b10;
        val = bus64 ? 13'(addr[15:3]) : 13'(addr[15:2]);
        cfg_bus64 = bus64; cpu_addr = addr; cpu_we = 1'b1; cpu_req = 1'b1;
        all_precharged = 1'b0;
        if (ok) begin
            for (int i = 0; i <= d; i++) exp_q.push_back(WAIT_R);
            exp_q.push_back(mk(cs, 1'b1, val, 1'b0, 1'b0, 1'b1));
            for (int i = 0; i < TMRD_TB; i++) exp_q.push_back(WAIT_R);
            exp_q.push_back(ACK_R);
        end else begin
            exp_q.push_back(REJECT_R);
        end
        check_cycle(tag);
        cpu_req = intrude;
        if (intrude) cpu_addr = 32'hFF94_08CC;
        if (ok) begin
            for (int i = 0; i < d; i++) begin
                check_cycle(tag);
                cpu_req = 1'b0;
            end
            cpu_req = 1'b0;
            all_precharged = 1'b1;
            for (int i = 0; i < TMRD_TB + 2; i++) check_cycle(tag);
            all_precharged = 1'b0;
        end
        check_cycle(tag);
    endtask

    task automatic norm_probe(input logic area, input logic eg, input logic ee,
                              input string tag);
        norm_area = area; norm_req = 1'b1;
        #1;
        vectors++;
        if (norm_gnt !== eg || norm_err !== ee) begin
            miscompares++;
            $display("FAIL %s: actual gnt=%b err=%b expected gnt=%b err=%b",
                     tag, norm_gnt, norm_err, eg, ee);
        end
        norm_req = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        // R11 reset state, during and after reset
        check_cycle("R11 in reset");
        check_cycle("R11 in reset");
        rst_n = 1'b1;
        check_cycle("R11 after reset");
        // R9 flags clear after reset
        norm_probe(1'b0, 1'b0, 1'b1, "R9 area0 unprogrammed");
        norm_probe(1'b1, 1'b0, 1'b1, "R9 area1 unprogrammed");
        // R1 R2 R7 R8: area0, 32-bit, offset 0x08C8 -> 0x232 (burst 4)
        mode_write(32'hFF90_08C8, 1'b0, 2, 1'b1, 1'b0, "R1 R2 R7 R8 area0 32b");
        norm_probe(1'b0, 1'b1, 1'b0, "R9 area0 programmed");
        norm_probe(1'b1, 1'b0, 1'b1, "R9 area1 still unprogrammed");
        // R1 R5: area1, 32-bit, burst 8 legal
        mode_write(32'hFF94_08CC, 1'b0, 0, 1'b1, 1'b0, "R1 R5 area1 32b burst8");
        norm_probe(1'b1, 1'b1, 1'b0, "R9 area1 programmed");
        // R3 R10: 64-bit shift, with an ignored strobe while busy
        mode_write(32'hFF90_0450, 1'b1, 1, 1'b1, 1'b1, "R3 R10 area0 64b busy strobe");
        // R5: burst 8 illegal on 64-bit bus
        mode_write(32'hFF94_0458, 1'b1, 0, 1'b0, 1'b0, "R5 64b burst8 refused");
        // R5: burst code 000 refused on 32-bit bus
        mode_write(32'hFF90_08C0, 1'b0, 0, 1'b0, 1'b0, "R5 32b burst code 000 refused");
        // R4: offset above range
        mode_write(32'hFF90_1008, 1'b0, 0, 1'b0, 1'b0, "R4 offset 0x1008 refused");
        // R4: high legal offset 0x0FEC -> 0x3FB
        mode_write(32'hFF94_0FEC, 1'b0, 1, 1'b1, 1'b0, "R4 offset 0x0FEC accepted");
        // R6: window read refused
        cpu_we = 1'b0; cpu_addr = 32'hFF90_08C8; cpu_req = 1'b1;
        exp_q.push_back(REJECT_R);
        check_cycle("R6 window read");
        cpu_req = 1'b0;
        check_cycle("R6 window read");
        // R10: write outside the windows ignored
        cpu_we = 1'b1; cpu_addr = 32'hFF98_08C8; cpu_req = 1'b1;
        check_cycle("R10 outside window");
        cpu_req = 1'b0;
        check_cycle("R10 outside window");
        check_cycle("R10 outside window");
        summary();
    end

endmodule